// File: doc/BRIEF.md
# Tick Match Timer

The tick match timer watches a free-running tick count supplied from outside and raises a single-cycle match pulse when that count reaches a programmed target. The target sits in a compare register that is one bit wider than the count. The extra top bit turns the interrupt off, and the lower bits hold the value that the count must reach. The pulse is meant to set a bit in a soft-interrupt pending register elsewhere in the core.

Software arms the timer by writing the compare register. The write takes effect only if its disable bit is clear and its target lies strictly ahead of the count in the write cycle. Each write replaces whatever was armed before, so only the latest target can ever fire. The count itself and any trap delivery are handled by neighbouring logic.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the compare register reads back with only its top bit (bit CNT_W) set and all lower bits zero, and matchPulse is low.
- R2: A write to the compare register is visible on cmpRdData in the cycle after the write, exactly as written, including the top bit.
- R3: The match compares all CNT_W low bits of the compare register against the full tickIn value, including targets at the very top of the count range.
- R4: A write with the top bit set arms nothing and cancels any match that is already armed, so no pulse follows it.
- R5: A write whose target is equal to or lower than tickIn in the write cycle arms nothing, and no pulse follows even when tickIn later passes that target.
- R6: When an armed target equals tickIn, matchPulse is high for exactly one cycle, the cycle after. The timer then disarms and does not fire again until the next write.
- R7: A new write replaces any previously armed target, and the older target never fires.
- R8: A write in the same cycle as a hit takes precedence: the old match is dropped and no pulse follows that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpWrEn | input | 1 | Write strobe for the compare register |
| cmpWrData | input | CNT_W+1 | Write value; top bit disables, low CNT_W bits are the target |
| tickIn | input | CNT_W | Current tick count |
| cmpRdData | output | CNT_W+1 | Compare register read-back |
| matchPulse | output | 1 | One-cycle pulse the cycle after an armed target is reached |

## Verification
The bench builds the timer with CNT_W set to 16, while the default of 63 is elaborated as well. The narrow count lets the bench place tickIn anywhere in its range, including near the all-ones top, within a handful of cycles. The bench also drives tickIn directly rather than through a counter. This lets it freeze the count on a target, step it backwards past a target, and line up a write with a hit in the same cycle.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmp;   // capture write data into compare register
    logic arm;       // arm a match on the new target
    logic disarm;    // drop the armed match
  } tmtStrobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic wrDisable; // write data carries the disable bit
    logic wrAhead;   // write target lies strictly ahead of tick
    logic hit;       // armed and tick equals the stored target
  } tmtFlags_t;

endpackage

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmtStrobe_t       strb,
  input  logic [CNT_W:0]   wrData,
  input  logic [CNT_W-1:0] tickIn,
  output tmtFlags_t        flags,
  output logic [CNT_W:0]   cmpQ
);

  localparam int REG_W = CNT_W + 1;
  localparam logic [REG_W-1:0] CMP_RESET = {1'b1, {CNT_W{1'b0}}};

  logic armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ <= CMP_RESET;
    end else if (strb.loadCmp) begin
      cmpQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (strb.arm) begin
      armedQ <= 1'b1;
    end else if (strb.disarm) begin
      armedQ <= 1'b0;
    end
  end

  logic [CNT_W-1:0] storedTarget;
  logic [CNT_W-1:0] newTarget;

  always_comb begin
    storedTarget    = cmpQ[CNT_W-1:0];
    newTarget       = wrData[CNT_W-1:0];
    flags.wrDisable = wrData[CNT_W];
    flags.wrAhead   = newTarget > tickIn;
    flags.hit       = armedQ && (storedTarget == tickIn);
  end

endmodule

// File: rtl/tmt_control.sv
module tmt_control
  import tmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  tmtFlags_t  flags,
  output tmtStrobe_t strb,
  output logic       pulseQ
);

  logic fire;
  logic armNew;

  always_comb begin
    // a write in the same cycle wins over a pending hit
    fire         = !wrEn && flags.hit;
    armNew       = wrEn && !flags.wrDisable && flags.wrAhead;
    strb.loadCmp = wrEn;
    strb.arm     = armNew;
    strb.disarm  = (wrEn && !armNew) || fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= fire;
    end
  end

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpWrEn,
  input  logic [CNT_W:0]   cmpWrData,
  input  logic [CNT_W-1:0] tickIn,
  output logic [CNT_W:0]   cmpRdData,
  output logic             matchPulse
);

  tmtStrobe_t strb;
  tmtFlags_t  flags;

  tmt_datapath #(.CNT_W(CNT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (cmpWrData),
    .tickIn (tickIn),
    .flags  (flags),
    .cmpQ   (cmpRdData)
  );

  tmt_control uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cmpWrEn),
    .flags  (flags),
    .strb   (strb),
    .pulseQ (matchPulse)
  );

endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
  parameter int CNT_W = 63
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmpWrEn,
  input logic [CNT_W:0]   cmpWrData,
  input logic [CNT_W-1:0] tickIn,
  input logic [CNT_W:0]   cmpRdData,
  input logic             matchPulse
);

  localparam logic [CNT_W:0] CMP_RESET = {1'b1, {CNT_W{1'b0}}};

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (cmpRdData == CMP_RESET) && !matchPulse);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> cmpRdData == $past(cmpWrData));

  assert_pulse_on_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(tickIn) == $past(cmpRdData[CNT_W-1:0]));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> !$past(cmpRdData[CNT_W]));

  assert_stale_write_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWrEn && (cmpWrData[CNT_W-1:0] <= tickIn)) |=> !matchPulse);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> !matchPulse);

endmodule

bind tick_match_timer tmt_checker #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cmpWrEn    (cmpWrEn),
  .cmpWrData  (cmpWrData),
  .tickIn     (tickIn),
  .cmpRdData  (cmpRdData),
  .matchPulse (matchPulse)
);

// File: tb/tb_tick_match_timer.sv
`timescale 1ns/1ps
module tb_tick_match_timer;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmpWrEn = 1'b0;
  logic [CW:0]   cmpWrData = '0;
  logic [CW-1:0] tickIn = '0;
  logic [CW:0]   cmpRdData;
  logic          matchPulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  string curReq = "R1";

  tick_match_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .tickIn(tickIn), .cmpRdData(cmpRdData), .matchPulse(matchPulse)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  longint mCmp = longint'(1) << CW;
  bit     mArmed = 0;
  bit     mPulse = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCmp = longint'(1) << CW; mArmed = 0; mPulse = 0;
    end else begin
      longint tgt, tk;
      bit hitNow;
      tk = longint'(tickIn);
      tgt = mCmp % (longint'(1) << CW);
      hitNow = mArmed && (tgt == tk);
      if (cmpWrEn) begin
        longint w;
        w = longint'(cmpWrData);
        mCmp = w;
        mArmed = (w < (longint'(1) << CW)) && (w > tk);
        mPulse = 0;
      end else begin
        mPulse = hitNow;
        if (hitNow) mArmed = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (matchPulse !== mPulse) begin
        errors++;
        $display("FAIL %s pulse act %0b exp %0b", curReq, matchPulse, mPulse);
      end
      checks++;
      if (longint'(cmpRdData) != mCmp) begin
        errors++;
        $display("FAIL %s cmpRdData act %0h exp %0h", curReq, cmpRdData, mCmp);
      end
      if (matchPulse) pulses++;
    end
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // one cycle: optional write, tick set to t (or incremented when t < 0)
  task automatic cyc(input bit we, input logic [CW:0] d, input int t);
    @(negedge clk);
    #1;
    cmpWrEn = we;
    cmpWrData = d;
    if (t < 0) tickIn = tickIn + 1'b1;
    else tickIn = t[CW-1:0];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, -1);
  endtask

  task automatic hold(input int n, input int t);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, t);
  endtask

  task automatic expectPulses(input int exp, input string req);
    @(negedge clk);
    #2;
    checks++;
    if (pulses != exp) begin
      errors++;
      $display("FAIL %s pulse count act %0d exp %0d", req, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: reset state
    checks++;
    if (cmpRdData !== {1'b1, {CW{1'b0}}} || matchPulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset act %0h/%0b exp %0h/0", cmpRdData, matchPulse, {1'b1, {CW{1'b0}}});
    end
    hold(4, 0);
    expectPulses(0, "R1");
    pulses = 0;

    // R2, R6: arm ahead, fire once, no refire when tick returns to target
    curReq = "R6";
    cyc(1'b1, 17'h00067, 100);
    run(3);   // tick reaches 103 at its last step
    hold(3, 103);
    checks++;
    if (cmpRdData !== 17'h00067) begin
      errors++;
      $display("FAIL R2 readback act %0h exp %0h", cmpRdData, 17'h00067);
    end
    run(5);
    hold(4, 103);
    expectPulses(1, "R6");

    // R5: equal and lagging targets
    curReq = "R5";
    cyc(1'b1, 17'd200, 200);
    run(10);
    cyc(1'b1, 17'd150, 200);
    hold(2, 140);
    run(20);
    expectPulses(0, "R5");

    // R4: disable write cancels armed match; disabled target ahead never fires
    curReq = "R4";
    cyc(1'b1, 17'd300, 290);
    run(3);
    cyc(1'b1, {1'b1, 16'd310}, -1);
    run(30);
    cyc(1'b1, {1'b1, 16'd330}, 320);
    run(20);
    checks++;
    if (cmpRdData !== {1'b1, 16'd330}) begin
      errors++;
      $display("FAIL R2 readback top bit act %0h exp %0h", cmpRdData, {1'b1, 16'd330});
    end
    expectPulses(0, "R4");

    // R7: newer write replaces older target
    curReq = "R7";
    cyc(1'b1, 17'd400, 390);
    run(2);
    cyc(1'b1, 17'd405, -1);
    run(25);
    expectPulses(1, "R7");
    cyc(1'b1, 17'd420, 410);
    cyc(1'b1, 17'd415, -1);   // earlier target replaces later one
    run(30);
    expectPulses(1, "R7");

    // R8: write in the hit cycle wins
    curReq = "R8";
    cyc(1'b1, 17'd500, 499);
    cyc(1'b1, 17'd510, 500);
    hold(2, 500);
    expectPulses(0, "R8");
    run(15);
    expectPulses(1, "R8");

    // R3: targets at the very top of the range
    curReq = "R3";
    cyc(1'b1, 17'h0FFFF, 16'hFFF0);
    run(20);
    expectPulses(1, "R3");
    cyc(1'b1, 17'h0FFFF, 16'hFFFF);
    run(5);
    expectPulses(0, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule